// File: doc/BRIEF.md
# Cell Balancing Measurement Sequencer

This block paces cell balancing for a series stack of up to ten cells. It counts a base tick into fixed periods of 128 ticks. Each period opens with a short window in which the cell comparators are sampled, and a balancing window fills the rest of the period. Successive balancing windows serve the even-numbered cells and then the odd-numbered cells, so a full balancing cycle takes two periods (256 ticks). A cell is shunted only when its above-threshold flag was set at the close of the latest measurement window. Shunts are allowed only while a charger is present and the balance offset code is nonzero.

At the close of each measurement window the block emits a one-cycle pulse, once per period, which drives the downstream fault-qualification counters. The block also computes the balance threshold in millivolts from the overvoltage code and the offset code, with a floor that the threshold never goes below. Reset or sleep entry restarts the sequence at an even-phase measurement window with every shunt off.

Top module: `cellbal_sequencer`

## Requirements
- R1: One period is exactly 128 ticks. Consecutive `done_o` pulses are separated by exactly 128 accepted ticks while no reset or sleep intervenes.
- R2: `meas_o` is high for the first 5 slots of each period (slots 0..4) and low for the remaining 123 slots. The output follows the tick edge by one clock.
- R3: `done_o` is high for exactly one clock, in the cycle after the tick that ends slot 4. The `above_i` flags are captured on that same tick.
- R4: The first balancing window after reset or sleep is the even phase, which may drive only bits 1,3,5,7,9 (cells 2,4,6,8,10, where cell k sits at bit k-1). The next window is the odd phase, which may drive only bits 0,2,4,6,8. The phases then keep alternating every period.
- R5: A shunt bit is set only if the matching flag captured in the latest measurement window was 1.
- R6: All shunts are 0 in the cycle after `bal_en_i` is low or `offs_code_i` is 0.
- R7: All shunts are 0 whenever `meas_o` is high.
- R8: Shunt bits at index greater than or equal to `cell_cnt_i` are always 0.
- R9: `bal_mv_o` equals 4100 + 50*ov − 50*off millivolts, where ov and off are the codes saturated at 8. The value is clamped to a minimum of 3750, registered, and 3750 while in reset.
- R10: While `rst` or `sleep_i` is high, the sequencer returns to slot 0 in the even phase. In that state `meas_o`=1, `done_o`=0, all shunts are 0 and the captured flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep entry, restarts the sequence |
| tick_i | input | 1 | One-clock base tick (1/32 of the overcurrent delay) |
| above_i | input | NCELL | Per-cell above-balance-threshold flags |
| bal_en_i | input | 1 | Charger detected, balancing permitted |
| cell_cnt_i | input | 4 | Number of populated cells |
| ov_code_i | input | 4 | Overvoltage threshold code (0..8) |
| offs_code_i | input | 4 | Balance offset code (0..8, 0 disables) |
| meas_o | output | 1 | Measurement window active |
| done_o | output | 1 | End-of-measurement pulse, once per period |
| shunt_o | output | NCELL | Per-cell shunt enables |
| bal_mv_o | output | 13 | Balance threshold in millivolts |

## Verification
The bench feeds random tick spacing with random flags, enables, cell counts and threshold codes, and compares every output with a reference model on every cycle. A flag pattern that changes between ticks separates capture at the close of the window from capture at any other moment. Directed runs hold all flags high so that the phase mask alone sets the shunt pattern, which separates the even and odd phases. Further directed runs use a zero offset, a five-cell stack and sleep pulses placed mid-period. Extreme code pairs exercise the threshold floor and saturation.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int CBS_BASE_MV  = 4100;
  localparam int CBS_STEP_MV  = 50;
  localparam int CBS_FLOOR_MV = 3750;
  localparam int CBS_CODE_MAX = 8;
  localparam int CBS_MVW      = 13;
  localparam int CBS_CODEW    = 4;
endpackage

// File: rtl/cbs_slot_timer.sv
module cbs_slot_timer #(
  parameter int SLOTS = 128,
  parameter int MEAS  = 5
) (
  input  logic clk,
  input  logic clr,
  input  logic tick_i,
  output logic meas_o,
  output logic done_o,
  output logic win_end_o,
  output logic bal_win_nx_o,
  output logic odd_nx_o
);
  localparam int CW = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST   = CW'(SLOTS - 1);
  localparam logic [CW-1:0] MEND   = CW'(MEAS - 1);
  localparam logic [CW-1:0] MSLOTS = CW'(MEAS);

  logic [CW-1:0] slot_q, slot_d;
  logic          odd_q, odd_d;
  logic          meas_q, done_q;

  always_comb begin
    slot_d = slot_q;
    odd_d  = odd_q;
    if (tick_i) begin
      if (slot_q == LAST) begin
        slot_d = '0;
        odd_d  = ~odd_q;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  assign win_end_o    = tick_i && (slot_q == MEND);
  assign bal_win_nx_o = (slot_d >= MSLOTS);
  assign odd_nx_o     = odd_d;

  always_ff @(posedge clk) begin
    if (clr) begin
      slot_q <= '0;
      odd_q  <= 1'b0;
      meas_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      odd_q  <= odd_d;
      meas_q <= (slot_d < MSLOTS);
      done_q <= win_end_o;
    end
  end

  assign meas_o = meas_q;
  assign done_o = done_q;

  // R1
  wrap_meas_chk: assert property (@(posedge clk) disable iff (clr)
    (tick_i && slot_q == LAST) |=> meas_o);
  // R2
  meas_close_chk: assert property (@(posedge clk) disable iff (clr)
    win_end_o |=> !meas_o);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (clr)
    done_o |=> !done_o);
endmodule

// File: rtl/cbs_thresh_calc.sv
module cbs_thresh_calc
  import cbs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CBS_CODEW-1:0] ov_code_i,
  input  logic [CBS_CODEW-1:0] offs_code_i,
  output logic [CBS_MVW-1:0]   bal_mv_o
);
  localparam logic [CBS_CODEW-1:0] CMAX = CBS_CODEW'(CBS_CODE_MAX);

  logic [CBS_CODEW-1:0] ov_c, of_c;
  logic [CBS_MVW-1:0]   mv_d, mv_q;

  assign ov_c = (ov_code_i   > CMAX) ? CMAX : ov_code_i;
  assign of_c = (offs_code_i > CMAX) ? CMAX : offs_code_i;

  always_comb begin
    int raw;
    raw  = CBS_BASE_MV + CBS_STEP_MV * int'(ov_c) - CBS_STEP_MV * int'(of_c);
    if (raw < CBS_FLOOR_MV) raw = CBS_FLOOR_MV;
    mv_d = CBS_MVW'(raw);
  end

  always_ff @(posedge clk) begin
    if (rst) mv_q <= CBS_MVW'(CBS_FLOOR_MV);
    else     mv_q <= mv_d;
  end

  assign bal_mv_o = mv_q;

  // R9
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    bal_mv_o >= CBS_MVW'(CBS_FLOOR_MV));
endmodule

// File: rtl/cbs_shunt_ctrl.sv
module cbs_shunt_ctrl #(
  parameter int NCELL = 10,
  parameter int CCW   = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             cap_i,
  input  logic [NCELL-1:0] above_i,
  input  logic             bal_win_nx_i,
  input  logic             odd_nx_i,
  input  logic             allow_i,
  input  logic [CCW-1:0]   cell_cnt_i,
  input  logic             meas_i,
  output logic [NCELL-1:0] shunt_o
);
  logic [NCELL-1:0] even_m, cnt_m, par_m;
  logic [NCELL-1:0] flags_q, flags_d, shunt_d, shunt_q;

  for (genvar i = 0; i < NCELL; i++) begin : g_mask
    assign even_m[i] = ((i % 2) == 1);
    assign cnt_m[i]  = (cell_cnt_i > CCW'(i));
  end

  assign par_m   = odd_nx_i ? ~even_m : even_m;
  assign flags_d = cap_i ? above_i : flags_q;
  assign shunt_d = flags_d & par_m & cnt_m & {NCELL{allow_i & bal_win_nx_i}};

  always_ff @(posedge clk) begin
    if (clr) begin
      flags_q <= '0;
      shunt_q <= '0;
    end else begin
      flags_q <= flags_d;
      shunt_q <= shunt_d;
    end
  end

  assign shunt_o = shunt_q;

  // R5
  shunt_flag_chk: assert property (@(posedge clk) disable iff (clr)
    (shunt_q & ~flags_q) == '0);
  // R7
  shunt_meas_chk: assert property (@(posedge clk) disable iff (clr)
    meas_i |-> (shunt_q == '0));
  // R6
  shunt_allow_chk: assert property (@(posedge clk) disable iff (clr)
    !allow_i |=> (shunt_q == '0));
endmodule

// File: rtl/cellbal_sequencer.sv
module cellbal_sequencer
  import cbs_pkg::*;
#(
  parameter int NCELL = 10,
  parameter int SLOTS = 128,
  parameter int MEAS  = 5,
  parameter int CCW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sleep_i,
  input  logic                 tick_i,
  input  logic [NCELL-1:0]     above_i,
  input  logic                 bal_en_i,
  input  logic [CCW-1:0]       cell_cnt_i,
  input  logic [CBS_CODEW-1:0] ov_code_i,
  input  logic [CBS_CODEW-1:0] offs_code_i,
  output logic                 meas_o,
  output logic                 done_o,
  output logic [NCELL-1:0]     shunt_o,
  output logic [CBS_MVW-1:0]   bal_mv_o
);
  logic clr, win_end, bal_win_nx, odd_nx, allow;

  assign clr   = rst | sleep_i;
  assign allow = bal_en_i && (offs_code_i != '0);

  cbs_slot_timer #(.SLOTS(SLOTS), .MEAS(MEAS)) u_timer (
    .clk(clk), .clr(clr), .tick_i(tick_i), .meas_o(meas_o), .done_o(done_o),
    .win_end_o(win_end), .bal_win_nx_o(bal_win_nx), .odd_nx_o(odd_nx)
  );

  cbs_shunt_ctrl #(.NCELL(NCELL), .CCW(CCW)) u_shunt (
    .clk(clk), .clr(clr), .cap_i(win_end), .above_i(above_i),
    .bal_win_nx_i(bal_win_nx), .odd_nx_i(odd_nx), .allow_i(allow),
    .cell_cnt_i(cell_cnt_i), .meas_i(meas_o), .shunt_o(shunt_o)
  );

  cbs_thresh_calc u_thresh (
    .clk(clk), .rst(rst), .ov_code_i(ov_code_i), .offs_code_i(offs_code_i),
    .bal_mv_o(bal_mv_o)
  );

  // R10
  sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (meas_o && !done_o && shunt_o == '0));
endmodule

// File: tb/cellbal_sequencer_bench.sv
`timescale 1ns/1ps
module cellbal_sequencer_bench;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, sleep = 1'b0, tick = 1'b0, bal_en = 1'b0;
  logic [N-1:0] above = '0;
  logic [3:0] cnt = 4'd10, ovc = 4'd0, ofc = 4'd0;
  logic meas, done;
  logic [N-1:0] shunt;
  logic [12:0] balmv;

  int checks = 0, errors = 0;
  int tk = 0;
  bit tk_valid = 0;

  // reference model state
  int m_slot = 0;
  bit m_odd = 0, m_meas = 1, m_done = 0;
  logic [N-1:0] m_flags = '0, m_shunt = '0;
  int m_bal = 3750;

  always #2 clk = ~clk;

  cellbal_sequencer u_cellbal_sequencer (
    .clk(clk), .rst(rst), .sleep_i(sleep), .tick_i(tick), .above_i(above),
    .bal_en_i(bal_en), .cell_cnt_i(cnt), .ov_code_i(ovc), .offs_code_i(ofc),
    .meas_o(meas), .done_o(done), .shunt_o(shunt), .bal_mv_o(balmv)
  );

  function automatic int exp_thresh(logic [3:0] o, logic [3:0] f);
    int a, b, r;
    a = (o > 8) ? 8 : int'(o);
    b = (f > 8) ? 8 : int'(f);
    r = 4100 + 50 * a - 50 * b;
    return (r < 3750) ? 3750 : r;
  endfunction

  function automatic logic [N-1:0] phase_mask(bit odd);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = odd ? (i % 2 == 0) : (i % 2 == 1);
    return m;
  endfunction

  function automatic logic [N-1:0] count_mask(logic [3:0] c);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < int'(c));
    return m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_slot = 0; m_odd = 0; m_flags = '0; m_meas = 1; m_done = 0;
      m_shunt = '0; m_bal = 3750;
    end else begin
      m_bal = exp_thresh(ovc, ofc);
      if (sleep) begin
        m_slot = 0; m_odd = 0; m_flags = '0; m_meas = 1; m_done = 0; m_shunt = '0;
      end else begin
        m_done = tick && (m_slot == 4);
        if (m_done) m_flags = above;
        if (tick) begin
          if (m_slot == 127) begin m_slot = 0; m_odd = ~m_odd; end
          else m_slot = m_slot + 1;
        end
        m_meas = (m_slot < 5);
        m_shunt = (m_slot >= 5 && bal_en && ofc != 0) ?
                  (m_flags & phase_mask(m_odd) & count_mask(cnt)) : '0;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    check(meas == m_meas, "R2 meas", meas, m_meas);
    check(done == m_done, "R3 done", done, m_done);
    check(shunt == m_shunt, "R4 shunt", shunt, m_shunt);
    check((shunt & ~m_flags) == '0, "R5 flag gate", shunt, m_flags);
    check((shunt & ~count_mask(cnt)) == '0, "R8 count", shunt, count_mask(cnt));
    if (meas) check(shunt == '0, "R7 meas off", shunt, 0);
    check(int'(balmv) == m_bal, "R9 threshold", balmv, m_bal);
    if (done) begin
      if (tk_valid) check(tk == 128, "R1 period", tk, 128);
      tk = 0; tk_valid = 1;
    end
  endtask

  task automatic step(bit t);
    @(negedge clk);
    if (!rst) compare();
    tick = t;
    if (t) tk++;
  endtask

  task automatic do_sleep();
    @(negedge clk);
    compare();
    sleep = 1; tick = 0;
    @(negedge clk);
    sleep = 0;
    check(meas && !done && shunt == '0, "R10 sleep", {meas, done, shunt}, {1'b1, 1'b0, {N{1'b0}}});
    tk = 0; tk_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(meas == 1 && done == 0 && shunt == '0, "R10 reset", {meas, done, shunt}, {1'b1, 1'b0, {N{1'b0}}});
    rst = 0;
    // even-phase pattern with all flags high
    above = '1; bal_en = 1; ofc = 4'd2; ovc = 4'd3; cnt = 4'd10;
    for (int i = 0; i < 6; i++) step(1);
    step(0);
    check(shunt == 10'b1010101010, "R4 even phase", shunt, 10'b1010101010);
    for (int i = 0; i < 128; i++) step(1);
    step(0);
    check(shunt == 10'b0101010101, "R4 odd phase", shunt, 10'b0101010101);
    // zero offset disables
    ofc = 4'd0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (i > 0) check(shunt == '0, "R6 zero offset", shunt, 0);
    end
    ofc = 4'd4; bal_en = 0;
    step(1); step(1);
    check(shunt == '0, "R6 no charger", shunt, 0);
    // five-cell stack
    bal_en = 1; cnt = 4'd5;
    for (int i = 0; i < 300; i++) begin
      step(1);
      check(shunt[9:5] == '0, "R8 five cells", shunt, 0);
    end
    // threshold extremes
    ovc = 4'd0; ofc = 4'd8; step(0); step(0);
    check(balmv == 13'd3750, "R9 floor", balmv, 3750);
    ovc = 4'd15; ofc = 4'd1; step(0); step(0);
    check(balmv == 13'd4450, "R9 saturate", balmv, 4450);
    do_sleep();
    // random mix
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      compare();
      tick = ($urandom_range(0, 2) != 0);
      if (tick) tk++;
      if ($urandom_range(0, 7) == 0) above = N'($urandom());
      if ($urandom_range(0, 200) == 0) bal_en = ~bal_en;
      if ($urandom_range(0, 400) == 0) cnt = 4'($urandom_range(5, 10));
      if ($urandom_range(0, 300) == 0) ofc = 4'($urandom_range(0, 9));
      if ($urandom_range(0, 300) == 0) ovc = 4'($urandom_range(0, 9));
      if ($urandom_range(0, 3000) == 0) begin
        tick = 0; tk = 0; tk_valid = 0; sleep = 1;
        @(negedge clk);
        sleep = 0;
        check(meas && shunt == '0, "R10 random sleep", {meas, shunt}, {1'b1, {N{1'b0}}});
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule